// File: doc/BRIEF.md
# SPI-to-BiSS Data Mailbox

This block hands a data word from a register-bus host (the SPI side) to a serial read-out host (the BiSS side). The storage is the same six bytes that normally hold the position counter. While the mailbox is idle, the counter logic may load those bytes freely. Once the SPI host starts writing into the mailbox window, counter loads are held off, so they cannot overwrite the message.

The SPI side writes bytes at addresses 0x20 to 0x25. When the byte at the top address of the selected word length has been written, a valid flag rises. The BiSS side sees this flag as the warning indication of channel 0. The BiSS side reads a word right-aligned to the selected length, together with two active-low status bits. Completing a channel-0 read releases the mailbox.

Top module: `mbox_spi_biss`

## Requirements
- R1: After reset, `rd_data` is zero, `rd_nwarn` is 1 and `rd_nerr` is 1.
- R2: A write to address 0x20+k (k = 0..5) stores the byte in bits [8k+7:8k] of the word, so 0x20 is the least significant byte. The stored value is visible on `rd_data` in the cycle after the write.
- R3: `len_sel` picks the word length: 0 gives 16 bits, 1 gives 24 bits, 2 gives 32 bits and 3 gives 48 bits. `rd_data` shows only the low bits of that length, and every bit above it reads 0.
- R4: The valid flag rises in the cycle after a write to the top byte of the selected length (0x21, 0x22, 0x23 or 0x25). Writes to any other address in the window leave the flag unchanged.
- R5: `rd_nwarn` is 0 exactly while the valid flag is set.
- R6: A `rd_done` pulse clears the valid flag and releases the mailbox. From the next cycle on, `rd_nwarn` and `rd_nerr` both read 1.
- R7: The mailbox is in use from the first write in the window until `rd_done`. While it is in use, `cnt_load` has no effect. While it is idle, `cnt_load` copies `cnt_val` into all six bytes.
- R8: `rd_nerr` is 0 while the mailbox is in use and the valid flag is not yet set, that is, while a word is only partly written.
- R9: Writes to addresses outside 0x20..0x25 change nothing.
- R10: If a write completes the word in the same cycle as `rd_done`, the valid flag is set after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | SPI-side byte write strobe |
| wr_addr | input | 8 | SPI-side byte address |
| wr_data | input | 8 | SPI-side write byte |
| len_sel | input | 2 | Word length code |
| cnt_load | input | 1 | Counter update strobe |
| cnt_val | input | 48 | Counter value to load |
| rd_done | input | 1 | BiSS side finished a channel-0 read |
| rd_data | output | 48 | Right-aligned mailbox word |
| rd_nerr | output | 1 | Active-low incomplete-word error |
| rd_nwarn | output | 1 | Active-low data-valid warning |

## Verification
The assertions assume that `len_sel` does not change while a word is being written. If it did, the completion address would move partway through a transfer. They also assume that `rd_done` arrives as a single-cycle pulse. The stimulus sets the length only while the mailbox is idle and drives every strobe for exactly one cycle. It never issues a counter load in the same cycle as the first mailbox write.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MBOX_BYTES = 6;
  localparam int DATA_W     = 8 * MBOX_BYTES;

  // number of bytes used by a length code
  function automatic int len_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2;
      2'd1:    return 3;
      2'd2:    return 4;
      default: return MBOX_BYTES;
    endcase
  endfunction

  // offset of the byte that completes a word
  function automatic int last_index(input logic [1:0] sel);
    return len_bytes(sel) - 1;
  endfunction

  // bit mask covering the selected length
  function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] sel);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < MBOX_BYTES; b++)
      if (b < len_bytes(sel)) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction
endpackage

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [7:0]        wr_idx,
  input  logic [7:0]        wr_data,
  input  logic              cnt_load,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic              busy,
  output logic [DATA_W-1:0] word
);
  logic [7:0] bytes_q [MBOX_BYTES];
  logic       cnt_take;

  assign cnt_take = cnt_load && !busy;

  for (genvar i = 0; i < MBOX_BYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                bytes_q[i] <= '0;
      else if (wr_hit && wr_idx == 8'(i))        bytes_q[i] <= wr_data;
      else if (cnt_take)                         bytes_q[i] <= cnt_val[8*i +: 8];
    end
    assign word[8*i +: 8] = bytes_q[i];
  end

  // R7
  cnt_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_hit) |=> $stable(word));
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
  import mbox_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_done,
  input  logic rd_done,
  output logic busy,
  output logic valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy <= 1'b0;
    else if (wr_hit)  busy <= 1'b1;
    else if (rd_done) busy <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid <= 1'b0;
    else if (wr_done) valid <= 1'b1;
    else if (rd_done) valid <= 1'b0;
  end

  // R7
  valid_in_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> busy);
  // R4
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(wr_done));
  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !wr_hit) |=> (!valid && !busy));
  // R10
  done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && wr_done) |=> valid);
endmodule

// File: rtl/mbox_format.sv
module mbox_format
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] word,
  input  logic [1:0]        len_sel,
  input  logic              busy,
  input  logic              valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_nerr,
  output logic              rd_nwarn
);
  assign rd_data  = word & len_mask(len_sel);
  assign rd_nwarn = !valid;
  assign rd_nerr  = !(busy && !valid);

  // R5 R8
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_nerr && !rd_nwarn));
endmodule

// File: rtl/mbox_spi_biss.sv
module mbox_spi_biss
  import mbox_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [1:0]        len_sel,
  input  logic              cnt_load,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_nerr,
  output logic              rd_nwarn
);
  localparam logic [7:0] TOP_ADDR = BASE_ADDR + 8'(MBOX_BYTES - 1);

  logic [7:0]        wr_idx;
  logic              wr_hit, wr_done, busy, valid;
  logic [DATA_W-1:0] word;

  assign wr_idx  = wr_addr - BASE_ADDR;
  assign wr_hit  = wr_en && wr_addr >= BASE_ADDR && wr_addr <= TOP_ADDR;
  assign wr_done = wr_hit && wr_idx == 8'(last_index(len_sel));

  mbox_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_idx(wr_idx),
    .wr_data(wr_data), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .busy(busy), .word(word));

  mbox_flags u_flags (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_done(wr_done),
    .rd_done(rd_done), .busy(busy), .valid(valid));

  mbox_format u_fmt (
    .clk(clk), .rst_n(rst_n), .word(word), .len_sel(len_sel),
    .busy(busy), .valid(valid), .rd_data(rd_data),
    .rd_nerr(rd_nerr), .rd_nwarn(rd_nwarn));

  // R9
  outside_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit && !cnt_load && !rd_done) |=> ($stable(rd_data) && $stable(rd_nwarn)));
endmodule

// File: tb/mbox_spi_biss_test.sv
module mbox_spi_biss_test;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, cnt_load = 0, rd_done = 0;
  logic [7:0]  wr_addr = 0, wr_data = 0;
  logic [1:0]  len_sel = 0;
  logic [47:0] cnt_val = 0;
  logic [47:0] rd_data;
  logic        rd_nerr, rd_nwarn;
  int          checks = 0, fails = 0;
  logic [7:0]  em [6];

  always #2 clk = ~clk;

  mbox_spi_biss uut (.*);

  function automatic logic [47:0] expect_word(input int sel);
    int nb;
    logic [47:0] v;
    nb = (sel == 3) ? 6 : sel + 2;
    v = 0;
    for (int k = 0; k < nb; k++) v = v + (48'(em[k]) << (8 * k));
    return v;
  endfunction

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic load(input logic [47:0] v);
    @(negedge clk); cnt_load = 1; cnt_val = v;
    @(negedge clk); cnt_load = 0;
  endtask

  task automatic done();
    @(negedge clk); rd_done = 1;
    @(negedge clk); rd_done = 0;
  endtask

  task automatic set_em(input logic [47:0] v);
    for (int k = 0; k < 6; k++) em[k] = v[8*k +: 8];
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [47:0] cv;
    len_sel = 3;
    repeat (3) @(negedge clk);
    chk("R1 data", rd_data, 0);
    chk("R1 nwarn", {47'd0, rd_nwarn}, 1);
    chk("R1 nerr", {47'd0, rd_nerr}, 1);
    rst_n = 1;

    // R7 idle load, R3 length sweep over one stored value
    cv = 48'h123456789ABC;
    load(cv); set_em(cv);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); len_sel = 2'(s);
      #1 chk($sformatf("R3 len %0d", s), rd_data, expect_word(s));
    end

    for (int s = 0; s < 4; s++) begin
      int nb;
      nb = (s == 3) ? 6 : s + 2;
      @(negedge clk); len_sel = 2'(s);
      cv = 48'hA5F00F5A3C00 ^ (48'(s) * 48'h010203040506);
      load(cv); set_em(cv);
      chk("R7 idle load", rd_data, expect_word(s));
      for (int k = 0; k < nb; k++) begin
        logic [7:0] d;
        d = 8'((s * 16 + k * 37 + 1) & 8'hFF);
        wr(8'h20 + 8'(k), d); em[k] = d;
        chk("R2 byte placed", rd_data, expect_word(s));
        if (k == 0) begin
          load(48'hFFFFFFFFFFFF);
          chk("R7 load blocked", rd_data, expect_word(s));
        end
        if (k < nb - 1) begin
          chk("R8 partial nerr", {47'd0, rd_nerr}, 0);
          chk("R4 not yet valid", {47'd0, rd_nwarn}, 1);
        end else begin
          chk("R4 R5 valid nwarn", {47'd0, rd_nwarn}, 0);
          chk("R8 complete nerr", {47'd0, rd_nerr}, 1);
        end
      end
      wr(8'h26, 8'h77); wr(8'h1F, 8'h88);
      chk("R9 outside ignored", rd_data, expect_word(s));
      chk("R9 flags kept", {46'd0, rd_nerr, rd_nwarn}, 48'd2);
      done();
      chk("R6 released", {46'd0, rd_nerr, rd_nwarn}, 48'd3);
      cv = 48'h0F0E0D0C0B0A;
      load(cv); set_em(cv);
      chk("R7 load after release", rd_data, expect_word(s));
    end

    // R4: bytes past the length never complete a 16-bit word
    @(negedge clk); len_sel = 0;
    wr(8'h20, 8'h11); wr(8'h22, 8'h22);
    chk("R4 beyond length", {47'd0, rd_nwarn}, 1);
    wr(8'h21, 8'h33);
    chk("R4 top byte", {47'd0, rd_nwarn}, 0);
    done();

    // R10: completion in the same cycle as a read release
    wr(8'h20, 8'h44);
    @(negedge clk); wr_en = 1; wr_addr = 8'h21; wr_data = 8'h55; rd_done = 1;
    @(negedge clk); wr_en = 0; rd_done = 0;
    chk("R10 valid kept", {47'd0, rd_nwarn}, 0);
    chk("R10 data", rd_data, 48'h5544);
    done();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule